// File: doc/BRIEF.md
# Hot-Swap Pass-Switch Sequencer

This block sequences the turn-on of an external pass switch when a card is plugged into a live supply rail. It takes digital flags from analog comparators: supply reset release, under- and over-voltage, current and power limiting, a fast breaker trip, output feedback, and a small-sense-voltage detector. It drives a two-bit gate command that selects strong pull-down, weak pull-down, full enhancement or linear regulation. It also drives a power-good output, a fault flag and a sticky shorted-switch flag.

An external timing capacitor is replaced by one saturating up/down counter. The insertion delay, the fault timeout and the restart wait all use this counter, each with its own charge or discharge step. After a timeout the sequencer either latches off or retries. A three-bit setting chooses how many retries are allowed. Each retry waits eight slow charge/discharge ramps of the counter, which keeps the on-time duty small when a fault persists.

Top module: `hotswap_seq`

## Requirements
- R1: While `porOk` is low the gate command is strong-off (code 0) and the timer is held at zero. Gate codes are 0 strong-off, 1 weak-off, 2 on, 3 regulate.
- R2: After `porOk` rises, the timer charges by `INS_STEP` per cycle and the gate command stays weak-off (1), even when `uvAct` is high. The gate reaches on after exactly 1 + TMR_TOP/INS_STEP + 1 + TMR_TOP/FAST_STEP + 1 clock edges when no supply fault is present.
- R3: Once the insertion delay ends, the timer discharges by `FAST_STEP`. The gate turns on (2) only after the timer is zero and both `uvAct` and `ovAct` are low.
- R4: While running, `curLim` or `pwrLim` gives gate code 3 and charges the timer by `FLT_STEP`. If limiting ends before the threshold, the gate returns to on and no fault is flagged.
- R5: If limiting is held for TMR_TOP/FLT_STEP + 1 edges, `faultOut` rises and the gate goes to weak-off. The timer never exceeds `TMR_TOP`.
- R6: With `latchMode` high, the gate stays weak-off after a fault. It comes back only after `uvAct` pulses high and clears, or after `porOk` is cycled.
- R7: With `latchMode` low, `retryCfg` sets the retry budget: 0 none, 1 one, 2 two, 3 four, 4 eight, 5 sixteen, 6 or 7 unlimited. When the budget is spent the sequencer latches off.
- R8: Each retry waits `RESTART_CYCLES` charge/discharge ramps of the timer, between `TMR_LO` and `TMR_TOP`, before the gate is driven again. The off time is at least RESTART_CYCLES*(TMR_TOP-TMR_LO)/RST_DN_STEP cycles.
- R9: While running, `cbTrip` gives strong-off (0) in the same cycle and charges the timer at the fault rate. If it clears before the threshold, the gate returns to limit control; if it is held, a fault follows after the same count as R5.
- R10: `uvAct` or `ovAct` while running gives weak-off (1) with no timeout charge. Clearing it gives gate on again at once.
- R11: `pgood` is high only while running with `fbGood` high and both `uvAct` and `ovAct` low.
- R12: `senseHi` while the gate command is 0 or 1 sets `shortFlag`, which holds until `porOk` falls. `senseHi` while the gate is on has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| porOk | input | 1 | Supply above power-on reset level |
| uvAct | input | 1 | Undervoltage (or enable low) active |
| ovAct | input | 1 | Overvoltage active |
| curLim | input | 1 | Current limit loop active |
| pwrLim | input | 1 | Power limit loop active |
| cbTrip | input | 1 | Fast circuit breaker tripped |
| fbGood | input | 1 | Output feedback above threshold |
| senseHi | input | 1 | Sense voltage above short-detect level |
| latchMode | input | 1 | 1 = latch off after fault, 0 = retry |
| retryCfg | input | 3 | Retry budget code |
| gateCmd | output | 2 | Gate command code |
| pgood | output | 1 | Power good |
| faultOut | output | 1 | Timed fault in progress or latched |
| shortFlag | output | 1 | Shorted pass switch detected |

## Verification
The breaker trip and current limiting can both be active in the same cycle. Both charge the one shared timer. The bench raises `cbTrip` and `curLim` on the same edge while running. It checks that strong-off wins at once over regulate, and that the fault still arrives after exactly the limit-timeout edge count, neither doubled nor halved. A table sweep also combines supply faults with limiting in one cycle. It checks the gate priority order: breaker, then supply fault, then limiting.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    GATE_OFF_STRONG = 2'd0,
    GATE_OFF_WEAK   = 2'd1,
    GATE_ON         = 2'd2,
    GATE_REG        = 2'd3
  } gate_e;

  typedef enum logic [2:0] {
    ST_RESET, ST_INSERT, ST_ARM, ST_RUN, ST_FAULT, ST_RESTART, ST_LATCH
  } seq_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic clr;
    logic chgIns;
    logic chgFlt;
    logic chgRst;
    logic disFast;
    logic disRst;
  } tmr_op_t;

endpackage

// File: rtl/hs_timer.sv
module hs_timer
  import hs_pkg::*;
#(
  parameter int TMR_TOP     = 200,
  parameter int TMR_LO      = 20,
  parameter int INS_STEP    = 1,
  parameter int FLT_STEP    = 8,
  parameter int FAST_STEP   = 50,
  parameter int RST_UP_STEP = 4,
  parameter int RST_DN_STEP = 1,
  localparam int TW = $clog2(TMR_TOP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_op_t       op,
  output logic [TW-1:0] tmrVal,
  output logic          atTop,
  output logic          atZero,
  output logic          atLow
);

  logic [TW-1:0] upStep, dnStep, nextUp, nextDn;
  logic [TW:0]   sum;
  logic          doUp, doDn;

  always_comb begin
    upStep = '0;
    dnStep = '0;
    if (op.chgIns) upStep = TW'(INS_STEP);
    if (op.chgFlt) upStep = TW'(FLT_STEP);
    if (op.chgRst) upStep = TW'(RST_UP_STEP);
    if (op.disFast) dnStep = TW'(FAST_STEP);
    if (op.disRst)  dnStep = TW'(RST_DN_STEP);
    doUp = op.chgIns | op.chgFlt | op.chgRst;
    doDn = op.disFast | op.disRst;
    sum    = {1'b0, tmrVal} + {1'b0, upStep};
    nextUp = (sum >= (TW+1)'(TMR_TOP)) ? TW'(TMR_TOP) : sum[TW-1:0];
    nextDn = (tmrVal > dnStep) ? (tmrVal - dnStep) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tmrVal <= '0;
    else if (op.clr)    tmrVal <= '0;
    else if (doUp)      tmrVal <= nextUp;
    else if (doDn)      tmrVal <= nextDn;
  end

  assign atTop  = (tmrVal == TW'(TMR_TOP));
  assign atZero = (tmrVal == '0);
  assign atLow  = (tmrVal <= TW'(TMR_LO));

endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int RESTART_CYCLES = 8,
  localparam int CW = $clog2(RESTART_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       porOk,
  input  logic       uvAct,
  input  logic       ovAct,
  input  logic       curLim,
  input  logic       pwrLim,
  input  logic       cbTrip,
  input  logic       fbGood,
  input  logic       senseHi,
  input  logic       latchMode,
  input  logic [2:0] retryCfg,
  input  logic       atTop,
  input  logic       atZero,
  input  logic       atLow,
  output tmr_op_t    op,
  output logic [1:0] gateCmd,
  output logic       pgood,
  output logic       faultOut,
  output logic       shortFlag
);

  seq_e          st, stNext;
  logic          rampUp, rampUpNext;
  logic [CW-1:0] cycCnt, cycCntNext;
  logic [4:0]    retryCnt, retryCntNext;
  logic [4:0]    retryLim;
  logic          limAct, supplyBad, unlimited, giveUp;
  gate_e         gate;

  assign limAct    = curLim | pwrLim;
  assign supplyBad = uvAct | ovAct;
  assign unlimited = (retryCfg >= 3'd6);
  assign retryLim  = 5'd1 << (retryCfg - 3'd1);
  assign giveUp    = latchMode | (retryCfg == 3'd0) | (!unlimited && retryCnt >= retryLim);

  always_comb begin
    stNext       = st;
    rampUpNext   = rampUp;
    cycCntNext   = cycCnt;
    retryCntNext = retryCnt;
    op           = '0;
    if (!porOk) begin
      stNext       = ST_RESET;
      op.clr       = 1'b1;
      retryCntNext = '0;
    end else begin
      unique case (st)
        ST_RESET: begin
          op.clr = 1'b1;
          stNext = ST_INSERT;
        end
        ST_INSERT: begin
          op.chgIns = 1'b1;
          if (atTop) stNext = ST_ARM;
        end
        ST_ARM: begin
          op.disFast = 1'b1;
          if (atZero && !supplyBad) stNext = ST_RUN;
        end
        ST_RUN: begin
          if (cbTrip || (limAct && !supplyBad)) begin
            op.chgFlt = 1'b1;
            if (atTop) stNext = ST_FAULT;
          end else begin
            op.disFast = 1'b1;
          end
        end
        ST_FAULT: begin
          op.disFast = 1'b1;
          if (atZero) begin
            if (giveUp) stNext = ST_LATCH;
            else begin
              stNext       = ST_RESTART;
              retryCntNext = retryCnt + 5'd1;
              rampUpNext   = 1'b1;
              cycCntNext   = '0;
            end
          end
        end
        ST_RESTART: begin
          if (rampUp) begin
            op.chgRst = 1'b1;
            if (atTop) rampUpNext = 1'b0;
          end else begin
            op.disRst = 1'b1;
            if (atLow) begin
              if (cycCnt == CW'(RESTART_CYCLES - 1)) stNext = ST_ARM;
              else begin
                cycCntNext = cycCnt + CW'(1);
                rampUpNext = 1'b1;
              end
            end
          end
        end
        ST_LATCH: begin
          op.disFast = 1'b1;
          if (uvAct) begin
            stNext       = ST_ARM;
            retryCntNext = '0;
          end
        end
        default: stNext = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RESET;
      rampUp   <= 1'b0;
      cycCnt   <= '0;
      retryCnt <= '0;
    end else begin
      st       <= stNext;
      rampUp   <= rampUpNext;
      cycCnt   <= cycCntNext;
      retryCnt <= retryCntNext;
    end
  end

  always_comb begin
    if (!porOk || st == ST_RESET) gate = GATE_OFF_STRONG;
    else if (st == ST_RUN) begin
      if (cbTrip)         gate = GATE_OFF_STRONG;
      else if (supplyBad) gate = GATE_OFF_WEAK;
      else if (limAct)    gate = GATE_REG;
      else                gate = GATE_ON;
    end else gate = GATE_OFF_WEAK;
  end

  assign gateCmd  = gate;
  assign pgood    = porOk && (st == ST_RUN) && fbGood && !supplyBad;
  assign faultOut = (st == ST_FAULT) || (st == ST_RESTART) || (st == ST_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shortFlag <= 1'b0;
    else if (!porOk)  shortFlag <= 1'b0;
    else if (senseHi && (gate == GATE_OFF_STRONG || gate == GATE_OFF_WEAK))
      shortFlag <= 1'b1;
  end

endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq
  import hs_pkg::*;
#(
  parameter int TMR_TOP        = 200,
  parameter int TMR_LO         = 20,
  parameter int INS_STEP       = 1,
  parameter int FLT_STEP       = 8,
  parameter int FAST_STEP      = 50,
  parameter int RST_UP_STEP    = 4,
  parameter int RST_DN_STEP    = 1,
  parameter int RESTART_CYCLES = 8,
  localparam int TW = $clog2(TMR_TOP + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       porOk,
  input  logic       uvAct,
  input  logic       ovAct,
  input  logic       curLim,
  input  logic       pwrLim,
  input  logic       cbTrip,
  input  logic       fbGood,
  input  logic       senseHi,
  input  logic       latchMode,
  input  logic [2:0] retryCfg,
  output logic [1:0] gateCmd,
  output logic       pgood,
  output logic       faultOut,
  output logic       shortFlag
);

  tmr_op_t       op;
  logic [TW-1:0] tmrVal;
  logic          atTop, atZero, atLow;

  hs_ctrl #(.RESTART_CYCLES(RESTART_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .porOk(porOk), .uvAct(uvAct), .ovAct(ovAct),
    .curLim(curLim), .pwrLim(pwrLim), .cbTrip(cbTrip), .fbGood(fbGood),
    .senseHi(senseHi), .latchMode(latchMode), .retryCfg(retryCfg),
    .atTop(atTop), .atZero(atZero), .atLow(atLow), .op(op),
    .gateCmd(gateCmd), .pgood(pgood), .faultOut(faultOut), .shortFlag(shortFlag)
  );

  hs_timer #(
    .TMR_TOP(TMR_TOP), .TMR_LO(TMR_LO), .INS_STEP(INS_STEP), .FLT_STEP(FLT_STEP),
    .FAST_STEP(FAST_STEP), .RST_UP_STEP(RST_UP_STEP), .RST_DN_STEP(RST_DN_STEP)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .op(op), .tmrVal(tmrVal),
    .atTop(atTop), .atZero(atZero), .atLow(atLow)
  );

endmodule

// File: rtl/hotswap_seq_chk.sv
module hotswap_seq_chk #(
  parameter int TMR_TOP = 200,
  localparam int TW = $clog2(TMR_TOP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          porOk,
  input logic          uvAct,
  input logic          ovAct,
  input logic          cbTrip,
  input logic          fbGood,
  input logic [1:0]    gateCmd,
  input logic          pgood,
  input logic          faultOut,
  input logic          shortFlag,
  input logic [TW-1:0] tmrVal
);

  p_strong_off_pre_por_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !porOk |-> gateCmd == 2'd0);

  p_tmr_zero_pre_por_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !porOk |=> tmrVal == '0);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmrVal <= TW'(TMR_TOP));

  p_fault_weak_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (faultOut && porOk) |-> gateCmd == 2'd1);

  p_cb_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cbTrip |-> gateCmd inside {2'd0, 2'd1});

  p_on_needs_supply_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gateCmd inside {2'd2, 2'd3} |-> !uvAct && !ovAct);

  p_pgood_qual_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> fbGood && !uvAct && !ovAct && porOk);

  p_short_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (shortFlag && porOk) |=> shortFlag);

endmodule

bind hotswap_seq hotswap_seq_chk #(.TMR_TOP(TMR_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .porOk(porOk), .uvAct(uvAct), .ovAct(ovAct),
  .cbTrip(cbTrip), .fbGood(fbGood), .gateCmd(gateCmd), .pgood(pgood),
  .faultOut(faultOut), .shortFlag(shortFlag), .tmrVal(tmrVal)
);

// File: tb/hotswap_seq_bench.sv
module hotswap_seq_bench;

  localparam int TOP = 200, LO = 20, INS = 1, FLT = 8, FAST = 50;
  localparam int RUP = 4, RDN = 1, RCYC = 8;
  localparam int INSERT_EDGES  = 1 + TOP/INS + 1 + TOP/FAST + 1;
  localparam int TIMEOUT_EDGES = TOP/FLT + 1;
  localparam int MIN_RESTART   = RCYC * (TOP - LO) / RDN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic porOk = 0, uvAct = 0, ovAct = 0, curLim = 0, pwrLim = 0, cbTrip = 0;
  logic fbGood = 0, senseHi = 0, latchMode = 1;
  logic [2:0] retryCfg = 3'd0;
  logic [1:0] gateCmd;
  logic pgood, faultOut, shortFlag;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hotswap_seq #(.TMR_TOP(TOP), .TMR_LO(LO), .INS_STEP(INS), .FLT_STEP(FLT),
    .FAST_STEP(FAST), .RST_UP_STEP(RUP), .RST_DN_STEP(RDN), .RESTART_CYCLES(RCYC))
  u_hotswap_seq (
    .clk(clk), .rst_n(rst_n), .porOk(porOk), .uvAct(uvAct), .ovAct(ovAct),
    .curLim(curLim), .pwrLim(pwrLim), .cbTrip(cbTrip), .fbGood(fbGood),
    .senseHi(senseHi), .latchMode(latchMode), .retryCfg(retryCfg),
    .gateCmd(gateCmd), .pgood(pgood), .faultOut(faultOut), .shortFlag(shortFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic powerUp(output int edges);
    porOk = 0; tick(3);
    porOk = 1; edges = 0;
    while (gateCmd != 2'd2 && edges < 5000) begin tick(1); edges++; end
  endtask

  task automatic countEpisodes(input int window, output int eps, output int minGap);
    bit prevReg = 1;
    int offStart = -1;
    eps = 1; minGap = 1 << 30;
    for (int i = 0; i < window; i++) begin
      bit isReg;
      tick(1);
      isReg = (gateCmd == 2'd3);
      if (isReg && !prevReg) begin
        eps++;
        if (offStart >= 0 && i - offStart < minGap) minGap = i - offStart;
      end
      if (!isReg && prevReg) offStart = i;
      prevReg = isReg;
    end
  endtask

  // cb, cur, pwr, uv, ov, fb, expected gate, expected pgood
  typedef struct packed {
    logic cb, cur, pwr, uv, ov, fb;
    logic [1:0] eGate;
    logic ePg;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'd3,1'b1},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'd3,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,2'd1,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'd1,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,2'd1,1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin : main
    int edges, eps, gap;
    // R1: reset state
    tick(3);
    check(gateCmd == 2'd0 && !pgood && !faultOut && !shortFlag, "R1 reset", gateCmd, 0);
    rst_n = 1; tick(4);
    check(gateCmd == 2'd0, "R1 por low", gateCmd, 0);

    // R2/R3: insertion with undervoltage held
    uvAct = 1; porOk = 1; tick(100);
    check(gateCmd == 2'd1, "R2 insertion weak-off", gateCmd, 1);
    tick(300);
    check(gateCmd == 2'd1, "R3 held by uv", gateCmd, 1);
    uvAct = 0; tick(1);
    check(gateCmd == 2'd2, "R3 on after uv clears", gateCmd, 2);

    // R2: exact insertion length
    powerUp(edges);
    check(edges == INSERT_EDGES, "R2 insertion edges", edges, INSERT_EDGES);

    // table sweep: R4 R9 R10 R11
    fbGood = 1; tick(5);
    foreach (VECS[i]) begin
      cbTrip = VECS[i].cb; curLim = VECS[i].cur; pwrLim = VECS[i].pwr;
      uvAct = VECS[i].uv; ovAct = VECS[i].ov; fbGood = VECS[i].fb;
      #1;
      check(gateCmd == VECS[i].eGate, $sformatf("R10 R9 R4 gate vec %0d", i), gateCmd, VECS[i].eGate);
      check(pgood == VECS[i].ePg, $sformatf("R11 pgood vec %0d", i), pgood, VECS[i].ePg);
      tick(1);
      cbTrip = 0; curLim = 0; pwrLim = 0; uvAct = 0; ovAct = 0; fbGood = 1;
      #1;
      check(gateCmd == 2'd2, $sformatf("R10 re-enable after vec %0d", i), gateCmd, 2);
      tick(10);
    end

    // R4: short limit pulse, no fault
    curLim = 1; tick(TOP/FLT - 5); curLim = 0; tick(10);
    check(gateCmd == 2'd2 && !faultOut, "R4 limit clears", faultOut, 0);

    // R12: sense high while on has no effect
    senseHi = 1; tick(3);
    check(!shortFlag, "R12 ignored while on", shortFlag, 0);
    senseHi = 0; tick(2);

    // R5: exact fault timeout (latch mode)
    latchMode = 1;
    curLim = 1; tick(TIMEOUT_EDGES - 1);
    check(gateCmd == 2'd3 && !faultOut, "R5 before timeout", gateCmd, 3);
    tick(1);
    check(gateCmd == 2'd1 && faultOut, "R5 timeout", gateCmd, 1);
    curLim = 0; tick(3000);
    check(gateCmd == 2'd1, "R6 stays latched", gateCmd, 1);
    uvAct = 1; tick(3); uvAct = 0; tick(10);
    check(gateCmd == 2'd2 && !faultOut, "R6 enable cycle restarts", gateCmd, 2);

    // R9: breaker and limit together; same timeout count
    cbTrip = 1; curLim = 1; #1;
    check(gateCmd == 2'd0, "R9 immediate strong-off", gateCmd, 0);
    tick(TIMEOUT_EDGES - 1);
    check(!faultOut, "R9 no fault early", faultOut, 0);
    tick(1);
    check(faultOut && gateCmd == 2'd1, "R9 breaker timeout", faultOut, 1);
    cbTrip = 0; curLim = 0; tick(20);
    // R6: por cycle clears latch
    powerUp(edges);
    check(edges == INSERT_EDGES && !faultOut, "R6 por cycle restarts", edges, INSERT_EDGES);
    tick(5);
    cbTrip = 1; tick(5); cbTrip = 0; #1;
    check(gateCmd == 2'd2 && !faultOut, "R9 short trip returns", gateCmd, 2);

    // R12: sense high with gate weak-off sets sticky flag
    uvAct = 1; senseHi = 1; tick(2); senseHi = 0; uvAct = 0; tick(3);
    check(shortFlag == 1'b1, "R12 flag set", shortFlag, 1);
    porOk = 0; tick(2);
    check(shortFlag == 1'b0, "R12 cleared by por", shortFlag, 0);

    // R7/R8: two retries
    latchMode = 0; retryCfg = 3'd2;
    powerUp(edges); tick(5);
    curLim = 1; #1;
    countEpisodes(8000, eps, gap);
    check(eps == 3, "R7 two retries", eps, 3);
    check(gap >= MIN_RESTART, "R8 restart length", gap, MIN_RESTART);
    check(gateCmd == 2'd1 && faultOut, "R7 latched after budget", gateCmd, 1);
    curLim = 0;

    // R7: no retries
    retryCfg = 3'd0;
    powerUp(edges); tick(5);
    curLim = 1; #1;
    countEpisodes(3000, eps, gap);
    check(eps == 1, "R7 zero retries", eps, 1);
    curLim = 0;

    // R7: unlimited
    retryCfg = 3'd7;
    powerUp(edges); tick(5);
    curLim = 1; #1;
    countEpisodes(8000, eps, gap);
    check(eps >= 4, "R7 unlimited retries", eps, 4);
    curLim = 0;

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule